// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block sits between decode and dispatch in an out-of-order core that keeps every value, committed or speculative, in a single physical register file. Each cycle it accepts a group of up to two instructions. It translates their architectural source operands into physical tags and hands each register-writing instruction a fresh physical destination. For each such instruction it also reports the physical register that the destination mapped to before, so the reorder buffer can carry that tag until the instruction retires. When the reorder buffer retires a writer, it passes the carried tag back, and the block appends it to the pool of free registers.

Speculation is handled with checkpoints. When an instruction in the group is flagged as a predicted branch, the block saves a copy of the mapping as it stands just after that instruction, together with the read position of the free pool, in one of a small number of slots. It returns the slot number as the branch tag. When the branch resolves correctly, the slot is released. When the branch mispredicts, the mapping and the pool read position are put back to the saved copy, and that slot and every slot taken after it are released.

Everything the rename outputs is combinational from the current state and the request. The state advances on the clock edge only when the group is accepted.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical i, and the free pool hands out physical NUM_ARCH, NUM_ARCH+1, ... NUM_PHYS-1 in ascending order.
- R2: Each source tag equals the current mapping of its architectural register. Architectural register 0 always yields physical 0 and is never remapped.
- R3: A lane whose valid, write and destination-nonzero conditions all hold is given the physical register at the front of the free pool, with lane 0 served before lane 1. Any other lane reports destination tag 0 and consumes nothing.
- R4: A writing lane reports the previous mapping of its destination. When both lanes write the same register, lane 1 reports lane 0's new tag. A non-writing lane reports 0.
- R5: A lane 1 source that names lane 0's written destination takes lane 0's new tag instead of the table value.
- R6: Each valid commit lane appends its tag to the back of the free pool, lane 0 ahead of lane 1, behind every register already free.
- R7: The whole group is refused (ready low, no state change) if the pool holds fewer registers than the group's writing lanes need.
- R8: A valid lane flagged as a branch takes the lowest-numbered free checkpoint slot, and a lane 1 branch takes the next lowest. The slot records the mapping and pool position as they stand after that lane's own write.
- R9: The whole group is refused if fewer checkpoint slots are free than the group has branches.
- R10: A resolve with the mispredict flag restores the mapping and the pool read position from the named slot, and releases that slot and every slot taken after it. No rename group is accepted in that cycle.
- R11: A resolve without the mispredict flag releases only the named slot and leaves the mapping untouched.
- R12: A lane with valid low changes no state, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rn_valid_i | input | 2 | Lane holds an instruction |
| rn_wr_i | input | 2 | Lane writes its destination |
| rn_br_i | input | 2 | Lane is a predicted branch |
| rn_rd_i | input | 2x3 | Architectural destination per lane |
| rn_rs1_i | input | 2x3 | First architectural source per lane |
| rn_rs2_i | input | 2x3 | Second architectural source per lane |
| rn_ready_o | output | 1 | Group accepted this cycle |
| rn_ps1_o | output | 2x5 | First physical source per lane |
| rn_ps2_o | output | 2x5 | Second physical source per lane |
| rn_pd_o | output | 2x5 | New physical destination per lane, 0 if none |
| rn_pold_o | output | 2x5 | Previous mapping of the destination, 0 if none |
| rn_btag_o | output | 2x2 | Checkpoint slot given to a branch lane |
| cm_valid_i | input | 2 | Commit lane returns a register |
| cm_pold_i | input | 2x5 | Register returned to the free pool |
| br_valid_i | input | 1 | A branch resolves this cycle |
| br_tag_i | input | 2 | Slot of the resolving branch |
| br_mis_i | input | 1 | The resolving branch was mispredicted |

## Verification
The bench uses the default sizes: 8 architectural registers, 32 physical registers and 4 checkpoint slots. With 24 registers free after reset, a dozen two-writer groups with no retirement empty the pool, so the refusal on register shortage is reached early. Two groups that each carry two branches fill all four slots, so the third is refused on slots. Because the pool is 32 deep and is indexed by a wrapping pointer, random traffic with rollbacks and retirements takes both pointers around the ring many times. Mispredicts that arrive while several slots are live exercise the release of younger checkpoints.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned LANES = 2;  // group width; lane logic in the top is written for two
  localparam int unsigned LCW   = 2;  // width of a 0..LANES count
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter  int unsigned NUM_ARCH = 8,
  parameter  int unsigned NUM_PHYS = 32,
  localparam int unsigned PW       = $clog2(NUM_PHYS),
  localparam int unsigned CW       = PW + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LCW-1:0]            pop_cnt_i,
  input  logic [LANES-1:0]          push_vld_i,
  input  logic [LANES-1:0][PW-1:0]  push_tag_i,
  input  logic                      restore_i,
  input  logic [CW-1:0]             restore_head_i,
  output logic [CW-1:0]             head_o,
  output logic [CW-1:0]             cnt_o,
  output logic [LANES-1:0][PW-1:0]  cand_o
);
  localparam int unsigned INIT_FREE = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0] ring_q [NUM_PHYS];
  logic [CW-1:0] head_q, tail_q, tail_d;
  logic [CW-1:0] wr_ptr [LANES];

  assign head_o = head_q;
  assign cnt_o  = tail_q - head_q;

  for (genvar l = 0; l < LANES; l++) begin : g_cand
    logic [PW-1:0] idx;
    assign idx       = head_q[PW-1:0] + PW'(l);
    assign cand_o[l] = ring_q[idx];
  end

  always_comb begin
    wr_ptr[0] = tail_q;
    for (int l = 1; l < LANES; l++) wr_ptr[l] = wr_ptr[l-1] + CW'(push_vld_i[l-1]);
    tail_d = wr_ptr[LANES-1] + CW'(push_vld_i[LANES-1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= CW'(INIT_FREE);
      for (int i = 0; i < NUM_PHYS; i++)
        ring_q[i] <= (i < INIT_FREE) ? PW'(i + NUM_ARCH) : '0;
    end else begin
      head_q <= restore_i ? restore_head_i : head_q + CW'(pop_cnt_i);
      tail_q <= tail_d;
      for (int l = 0; l < LANES; l++)
        if (push_vld_i[l]) ring_q[wr_ptr[l][PW-1:0]] <= push_tag_i[l];
    end
  end

  p_pop_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_cnt_i) <= cnt_o);
  p_capacity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(INIT_FREE));
  p_no_zero_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_vld_i[0] |-> push_tag_i[0] != '0);
  p_rollback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> head_q == $past(restore_head_i));
endmodule

// File: rtl/rn_snap_ctrl.sv
module rn_snap_ctrl
  import rn_pkg::*;
#(
  parameter  int unsigned NUM_SNAP = 4,
  localparam int unsigned SW       = $clog2(NUM_SNAP)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          alloc_i,
  input  logic                      res_vld_i,
  input  logic [SW-1:0]             res_tag_i,
  input  logic                      res_mis_i,
  output logic [LANES-1:0][SW-1:0]  slot_o,
  output logic [SW:0]               free_cnt_o
);
  logic [NUM_SNAP-1:0] valid_q, valid_d, kill, avail;
  logic [NUM_SNAP-1:0] older_q [NUM_SNAP];
  logic [NUM_SNAP-1:0] older_d [NUM_SNAP];

  // lowest free slot per lane; a lane that allocates hides its slot from later lanes
  always_comb begin
    avail = ~valid_q;
    for (int l = 0; l < LANES; l++) begin
      slot_o[l] = '0;
      for (int s = NUM_SNAP - 1; s >= 0; s--)
        if (avail[s]) slot_o[l] = SW'(s);
      if (alloc_i[l]) avail[slot_o[l]] = 1'b0;
    end
  end

  always_comb begin
    free_cnt_o = '0;
    for (int s = 0; s < NUM_SNAP; s++) free_cnt_o += (SW+1)'(!valid_q[s]);
  end

  // a mispredict also kills every slot that recorded it as older
  always_comb begin
    kill = '0;
    if (res_vld_i) begin
      kill[res_tag_i] = 1'b1;
      if (res_mis_i)
        for (int t = 0; t < NUM_SNAP; t++)
          if (valid_q[t] && older_q[t][res_tag_i]) kill[t] = 1'b1;
    end
  end

  always_comb begin
    valid_d = valid_q & ~kill;
    for (int t = 0; t < NUM_SNAP; t++) older_d[t] = older_q[t] & ~kill;
    for (int l = 0; l < LANES; l++)
      if (alloc_i[l]) begin
        older_d[slot_o[l]] = valid_d;
        valid_d[slot_o[l]] = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int t = 0; t < NUM_SNAP; t++) older_q[t] <= '0;
    end else begin
      valid_q <= valid_d;
      for (int t = 0; t < NUM_SNAP; t++) older_q[t] <= older_d[t];
    end
  end

  p_slot_budget_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(alloc_i) <= int'(free_cnt_o));
  p_mis_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_i && res_mis_i) |=> !valid_q[$past(res_tag_i)]);
  p_ok_keeps_others_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_i && !res_mis_i) |=>
      (($past(valid_q) & ~(NUM_SNAP'(1) << $past(res_tag_i))) & ~valid_q) == '0);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
#(
  parameter  int unsigned NUM_ARCH = 8,
  parameter  int unsigned NUM_PHYS = 32,
  parameter  int unsigned NUM_SNAP = 4,
  localparam int unsigned AW       = $clog2(NUM_ARCH),
  localparam int unsigned PW       = $clog2(NUM_PHYS),
  localparam int unsigned SW       = $clog2(NUM_SNAP),
  localparam int unsigned CW       = PW + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0]              wr_i,
  input  logic [LANES-1:0][AW-1:0]      rd_i,
  input  logic [LANES-1:0][PW-1:0]      pd_i,
  input  logic [LANES-1:0]              snap_i,
  input  logic [LANES-1:0][SW-1:0]      snap_slot_i,
  input  logic [LANES-1:0][CW-1:0]      snap_head_i,
  input  logic                          restore_i,
  input  logic [SW-1:0]                 restore_slot_i,
  output logic [NUM_ARCH-1:0][PW-1:0]   map_o,
  output logic [CW-1:0]                 restore_head_o
);
  typedef logic [NUM_ARCH-1:0][PW-1:0] map_t;

  map_t          map_q;
  map_t          stage [LANES];
  map_t          snap_map_q [NUM_SNAP];
  logic [CW-1:0] snap_head_q [NUM_SNAP];

  assign map_o          = map_q;
  assign restore_head_o = snap_head_q[restore_slot_i];

  // mapping as seen just after each lane's write
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      stage[l] = (l == 0) ? map_q : stage[(l == 0) ? 0 : l - 1];
      if (wr_i[l]) stage[l][rd_i[l]] = pd_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      for (int s = 0; s < NUM_SNAP; s++) begin
        snap_map_q[s]  <= '0;
        snap_head_q[s] <= '0;
      end
    end else begin
      map_q <= restore_i ? snap_map_q[restore_slot_i] : stage[LANES-1];
      for (int l = 0; l < LANES; l++)
        if (snap_i[l]) begin
          snap_map_q[snap_slot_i[l]]  <= stage[l];
          snap_head_q[snap_slot_i[l]] <= snap_head_i[l];
        end
    end
  end

  p_zero_pinned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q[0] == '0);
  p_restore_map_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> map_q == $past(snap_map_q[restore_slot_i]));
  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i[0] && !restore_i && !(wr_i[1] && rd_i[1] == rd_i[0]))
      |=> map_q[$past(rd_i[0])] == $past(pd_i[0]));
endmodule

// File: rtl/rn_rename.sv
module rn_rename
  import rn_pkg::*;
#(
  parameter  int unsigned NUM_ARCH = 8,
  parameter  int unsigned NUM_PHYS = 32,
  parameter  int unsigned NUM_SNAP = 4,
  localparam int unsigned AW       = $clog2(NUM_ARCH),
  localparam int unsigned PW       = $clog2(NUM_PHYS),
  localparam int unsigned SW       = $clog2(NUM_SNAP),
  localparam int unsigned CW       = PW + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          rn_valid_i,
  input  logic [LANES-1:0]          rn_wr_i,
  input  logic [LANES-1:0]          rn_br_i,
  input  logic [LANES-1:0][AW-1:0]  rn_rd_i,
  input  logic [LANES-1:0][AW-1:0]  rn_rs1_i,
  input  logic [LANES-1:0][AW-1:0]  rn_rs2_i,
  output logic                      rn_ready_o,
  output logic [LANES-1:0][PW-1:0]  rn_ps1_o,
  output logic [LANES-1:0][PW-1:0]  rn_ps2_o,
  output logic [LANES-1:0][PW-1:0]  rn_pd_o,
  output logic [LANES-1:0][PW-1:0]  rn_pold_o,
  output logic [LANES-1:0][SW-1:0]  rn_btag_o,
  input  logic [LANES-1:0]          cm_valid_i,
  input  logic [LANES-1:0][PW-1:0]  cm_pold_i,
  input  logic                      br_valid_i,
  input  logic [SW-1:0]             br_tag_i,
  input  logic                      br_mis_i
);
  logic [LANES-1:0]          wreq, breq, wfire, bfire;
  logic [LCW-1:0]            need_regs, need_br, pop_cnt;
  logic                      restore;
  logic [CW-1:0]             fl_head, fl_cnt, rst_head;
  logic [LANES-1:0][CW-1:0]  snap_head;
  logic [LANES-1:0][PW-1:0]  cand, pd;
  logic [SW:0]               snap_free;
  logic [NUM_ARCH-1:0][PW-1:0] map;
  logic                      byp_s1, byp_s2, byp_rd;

  always_comb begin
    need_regs = '0;
    need_br   = '0;
    for (int l = 0; l < LANES; l++) begin
      wreq[l]   = rn_valid_i[l] & rn_wr_i[l] & (rn_rd_i[l] != '0);
      breq[l]   = rn_valid_i[l] & rn_br_i[l];
      need_regs += LCW'(wreq[l]);
      need_br   += LCW'(breq[l]);
    end
  end

  assign restore    = br_valid_i & br_mis_i;
  assign rn_ready_o = !restore && (CW'(need_regs) <= fl_cnt) && ((SW+1)'(need_br) <= snap_free);
  assign wfire      = wreq & {LANES{rn_ready_o}};
  assign bfire      = breq & {LANES{rn_ready_o}};
  assign pop_cnt    = LCW'(wfire[0]) + LCW'(wfire[1]);

  // lane 1 sees lane 0's destination before the table does
  assign byp_s1 = wreq[0] && (rn_rs1_i[1] == rn_rd_i[0]);
  assign byp_s2 = wreq[0] && (rn_rs2_i[1] == rn_rd_i[0]);
  assign byp_rd = wreq[0] && (rn_rd_i[1]  == rn_rd_i[0]);

  assign pd[0] = cand[0];
  assign pd[1] = wreq[0] ? cand[1] : cand[0];

  assign rn_ps1_o[0]  = map[rn_rs1_i[0]];
  assign rn_ps2_o[0]  = map[rn_rs2_i[0]];
  assign rn_ps1_o[1]  = byp_s1 ? pd[0] : map[rn_rs1_i[1]];
  assign rn_ps2_o[1]  = byp_s2 ? pd[0] : map[rn_rs2_i[1]];
  assign rn_pd_o[0]   = wreq[0] ? pd[0] : '0;
  assign rn_pd_o[1]   = wreq[1] ? pd[1] : '0;
  assign rn_pold_o[0] = wreq[0] ? map[rn_rd_i[0]] : '0;
  assign rn_pold_o[1] = !wreq[1] ? '0 : (byp_rd ? pd[0] : map[rn_rd_i[1]]);

  assign snap_head[0] = fl_head + CW'(wfire[0]);
  assign snap_head[1] = fl_head + CW'(pop_cnt);

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pop_cnt_i      (pop_cnt),
    .push_vld_i     (cm_valid_i),
    .push_tag_i     (cm_pold_i),
    .restore_i      (restore),
    .restore_head_i (rst_head),
    .head_o         (fl_head),
    .cnt_o          (fl_cnt),
    .cand_o         (cand)
  );

  rn_snap_ctrl #(.NUM_SNAP(NUM_SNAP)) u_snap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (bfire),
    .res_vld_i  (br_valid_i),
    .res_tag_i  (br_tag_i),
    .res_mis_i  (br_mis_i),
    .slot_o     (rn_btag_o),
    .free_cnt_o (snap_free)
  );

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_SNAP(NUM_SNAP)) u_map (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (wfire),
    .rd_i           (rn_rd_i),
    .pd_i           (pd),
    .snap_i         (bfire),
    .snap_slot_i    (rn_btag_o),
    .snap_head_i    (snap_head),
    .restore_i      (restore),
    .restore_slot_i (br_tag_i),
    .map_o          (map),
    .restore_head_o (rst_head)
  );

  p_distinct_dest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wfire) |-> rn_pd_o[0] != rn_pd_o[1]);
  p_refused_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rn_ready_o && !restore) |=> $stable(fl_head));
endmodule

// File: tb/rn_rename_test.sv
module rn_rename_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] rn_valid, rn_wr, rn_br;
  logic [1:0][2:0] rn_rd, rn_rs1, rn_rs2;
  logic rn_ready;
  logic [1:0][4:0] ps1, ps2, pd, pold, cm_pold;
  logic [1:0][1:0] btag;
  logic [1:0] cm_valid;
  logic br_valid, br_mis;
  logic [1:0] br_tag;

  int vectors = 0, miscompares = 0;

  // reference state
  int map_m [NA];
  int fl_m [$];
  int log_m [$];
  int pend_m [$];
  bit sv [NS];
  bit [NS-1:0] sold [NS];
  int smap [NS][NA];
  int slog [NS];
  int spend [NS];
  int ck = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rn_rename uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rn_valid_i(rn_valid), .rn_wr_i(rn_wr), .rn_br_i(rn_br),
    .rn_rd_i(rn_rd), .rn_rs1_i(rn_rs1), .rn_rs2_i(rn_rs2),
    .rn_ready_o(rn_ready), .rn_ps1_o(ps1), .rn_ps2_o(ps2),
    .rn_pd_o(pd), .rn_pold_o(pold), .rn_btag_o(btag),
    .cm_valid_i(cm_valid), .cm_pold_i(cm_pold),
    .br_valid_i(br_valid), .br_tag_i(br_tag), .br_mis_i(br_mis)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    rn_valid = '0; rn_wr = '0; rn_br = '0;
    rn_rd = '0; rn_rs1 = '0; rn_rs2 = '0;
    cm_valid = '0; cm_pold = '0;
    br_valid = 1'b0; br_tag = '0; br_mis = 1'b0;
    ck = 0;
  endtask

  task automatic set_lane(int l, bit v, bit w, bit b, int rd, int s1, int s2);
    rn_valid[l] = v; rn_wr[l] = w; rn_br[l] = b;
    rn_rd[l] = 3'(rd); rn_rs1[l] = 3'(s1); rn_rs2[l] = 3'(s2);
  endtask

  // retire only instructions older than every live checkpoint
  task automatic set_commit(int want);
    int lim = pend_m.size();
    for (int s = 0; s < NS; s++) if (sv[s] && spend[s] < lim) lim = spend[s];
    ck = (want < lim) ? want : lim;
    for (int k = 0; k < 2; k++) begin
      cm_valid[k] = (k < ck);
      cm_pold[k]  = (k < ck) ? 5'(pend_m[k]) : '0;
    end
  endtask

  task automatic set_resolve(int tag, bit mis);
    br_valid = 1'b1; br_tag = 2'(tag); br_mis = mis;
  endtask

  task automatic run_cycle();
    int need = 0, nb = 0, fs = 0, e_pd, e_po, s;
    bit mis, e_rdy, w, b;
    bit [NS-1:0] kill;
    #1;
    for (int l = 0; l < 2; l++) begin
      need += (rn_valid[l] && rn_wr[l] && rn_rd[l] != 0) ? 1 : 0;
      nb   += (rn_valid[l] && rn_br[l]) ? 1 : 0;
    end
    for (int t = 0; t < NS; t++) fs += sv[t] ? 0 : 1;
    mis   = br_valid && br_mis;
    e_rdy = !mis && need <= fl_m.size() && nb <= fs;
    chk("R7 R9 R10", "ready", int'(rn_ready), int'(e_rdy));
    if (e_rdy) begin
      for (int l = 0; l < 2; l++) begin
        if (!rn_valid[l]) continue;  // R12: an idle lane is skipped by the model
        chk("R2 R5", $sformatf("ps1[%0d]", l), int'(ps1[l]), map_m[rn_rs1[l]]);
        chk("R2 R5", $sformatf("ps2[%0d]", l), int'(ps2[l]), map_m[rn_rs2[l]]);
        w = rn_wr[l] && rn_rd[l] != 0;
        b = rn_br[l];
        e_pd = 0; e_po = 0;
        if (w) begin
          e_pd = fl_m.pop_front();
          log_m.push_back(e_pd);
          e_po = map_m[rn_rd[l]];
          map_m[rn_rd[l]] = e_pd;
          pend_m.push_back(e_po);
        end
        chk("R1 R3 R6 R12", $sformatf("pd[%0d]", l), int'(pd[l]), e_pd);
        chk("R4", $sformatf("pold[%0d]", l), int'(pold[l]), e_po);
        if (b) begin
          s = 0;
          while (sv[s]) s++;
          chk("R8", $sformatf("btag[%0d]", l), int'(btag[l]), s);
          for (int a = 0; a < NA; a++) smap[s][a] = map_m[a];
          slog[s] = log_m.size();
          spend[s] = pend_m.size();
          for (int t = 0; t < NS; t++) sold[s][t] = sv[t];
          sv[s] = 1'b1;
        end
      end
    end
    if (br_valid) begin
      s = int'(br_tag);
      kill = '0;
      kill[s] = 1'b1;
      if (br_mis) begin
        for (int a = 0; a < NA; a++) map_m[a] = smap[s][a];
        for (int i = log_m.size() - 1; i >= slog[s]; i--) fl_m.push_front(log_m[i]);
        while (log_m.size() > slog[s]) void'(log_m.pop_back());
        while (pend_m.size() > spend[s]) void'(pend_m.pop_back());
        for (int t = 0; t < NS; t++) if (sv[t] && sold[t][s]) kill[t] = 1'b1;
      end
      for (int t = 0; t < NS; t++) begin
        if (kill[t]) sv[t] = 1'b0;
        sold[t] = sold[t] & ~kill;
      end
    end
    for (int k = 0; k < ck; k++) fl_m.push_back(pend_m.pop_front());
    for (int t = 0; t < NS; t++) if (sv[t]) spend[t] -= ck;
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int live [$];
    clear_in();
    for (int a = 0; a < NA; a++) map_m[a] = a;
    for (int p = NA; p < 32; p++) fl_m.push_back(p);
    for (int t = 0; t < NS; t++) begin sv[t] = 0; sold[t] = '0; end
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing requested
    #1 chk("R1", "ready after reset", int'(rn_ready), 1);
    @(negedge clk);
    // R1 R5: first allocations and source bypass
    set_lane(0, 1, 1, 0, 1, 1, 0); set_lane(1, 1, 1, 0, 2, 1, 2); run_cycle();
    // R4: both lanes write the same register
    set_lane(0, 1, 1, 0, 3, 2, 1); set_lane(1, 1, 1, 0, 3, 3, 3); run_cycle();
    // R3 R12: r0 destination and an idle lane with live fields
    set_lane(0, 1, 1, 0, 0, 0, 3); set_lane(1, 0, 1, 1, 4, 4, 4); run_cycle();
    // R8: branch in lane 0 that also writes, lane 1 writes after it
    set_lane(0, 1, 1, 1, 5, 1, 2); set_lane(1, 1, 1, 0, 5, 5, 0); run_cycle();
    set_lane(0, 1, 1, 0, 6, 5, 3); run_cycle();
    // R10: mispredict refuses the group and rolls back
    set_lane(0, 1, 1, 0, 7, 5, 6); set_resolve(0, 1); run_cycle();
    set_lane(0, 1, 1, 0, 6, 5, 6); set_lane(1, 1, 0, 0, 0, 6, 5); run_cycle();
    // R7: drain the pool without retirement
    for (int i = 0; i < 14; i++) begin
      set_lane(0, 1, 1, 0, 1 + i % 7, i % 8, 5); set_lane(1, 1, 1, 0, 1 + (i + 3) % 7, 1 + i % 7, 2);
      run_cycle();
    end
    // R6: retirement refills the back of the pool
    for (int i = 0; i < 6; i++) begin
      set_commit(2); set_lane(0, 1, 1, 0, 2, 3, 4); run_cycle();
    end
    // R9: fill every slot, then one more group of branches
    for (int i = 0; i < 3; i++) begin
      set_lane(0, 1, 0, 1, 0, 1, 2); set_lane(1, 1, 0, 1, 0, 3, 4); run_cycle();
    end
    // R11: correct resolve frees only slot 1, then it is reused
    set_resolve(1, 0); run_cycle();
    set_lane(0, 1, 1, 1, 3, 3, 1); run_cycle();
    set_resolve(0, 0); run_cycle();
    set_resolve(2, 1); set_commit(2); run_cycle();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      for (int l = 0; l < 2; l++)
        set_lane(l, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 6) == 0,
                 int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      if ($urandom % 3 == 0) rn_rs1[1] = rn_rd[0];
      if ($urandom % 5 == 0) rn_rd[1]  = rn_rd[0];
      live.delete();
      for (int t = 0; t < NS; t++) if (sv[t]) live.push_back(t);
      if (live.size() > 0 && $urandom % 3 == 0)
        set_resolve(live[$urandom % live.size()], ($urandom % 3) == 0);
      set_commit(int'($urandom % 3));
      run_cycle();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule